// File: doc/BRIEF.md
# Start/Done Handshaked Three-Operand Adder

This core performs one addition per transaction: it takes two scalar operands and the current value of a read-modify-write argument, adds all three, and returns the result. The same result appears on two ports. One is the function return value. The other is the output half of the read-modify-write argument, which is split into an input port and a separate output port.

A block-level handshake controls each transaction. A start request launches it. The idle flag drops while the core is busy. A ready pulse reports that every input has been taken, and a done pulse reports that the return value is valid. The output half of the read-modify-write argument has its own one-cycle valid strobe.

The scalar inputs have no handshake. The environment must hold them steady from the start request until the core has read them, which happens at the end of the first busy cycle. After that the inputs may change freely. If start is still high when done is reported, the next transaction follows at once and idle does not rise in between.

Top module: `hs_add_core`

## Requirements
- R1: While reset is asserted, and after it is released until the next start request, idle_o is 1 and ready_o, done_o and acc_vld_o are 0.
- R2: When start_i is sampled high on a clock edge while the core is idle, idle_o is 0 in the following cycle and stays 0 until the transaction ends.
- R3: Operands are read on the clock edge that ends the first busy cycle. ready_o is 1 in exactly the second busy cycle. Input changes made after that edge do not affect the result.
- R4: ret_o and acc_o both equal (op_a_i + op_b_i + acc_i) modulo 2^32, using the values read under R3.
- R5: acc_vld_o is 1 for exactly one cycle per transaction, in the third busy cycle, which is the cycle right after ready_o.
- R6: done_o is 1 for exactly one cycle per transaction, in the same cycle as acc_vld_o, and marks ret_o as valid. ready_o and done_o are never high together.
- R7: If start_i is 0 in the done cycle, idle_o is 1 in the next cycle.
- R8: If start_i is 1 in the done cycle, a new transaction begins in the next cycle. idle_o stays 0, and that new transaction's operands are read at the end of that next cycle.
- R9: While the core is idle with start_i low, it stays idle, raises no strobes, and ret_o keeps the last result. start_i is ignored while the core is busy, except in the done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the core |
| start_i | input | 1 | Transaction request |
| op_a_i | input | 32 | First scalar operand (no handshake) |
| op_b_i | input | 32 | Second scalar operand (no handshake) |
| acc_i | input | 32 | Input half of the read-modify-write argument |
| idle_o | output | 1 | High when no transaction is in progress |
| ready_o | output | 1 | One-cycle pulse: all inputs have been read |
| done_o | output | 1 | One-cycle pulse: transaction finished, ret_o is valid |
| acc_o | output | 32 | Output half of the read-modify-write argument |
| acc_vld_o | output | 1 | One-cycle valid strobe for acc_o |
| ret_o | output | 32 | Return value |

## Verification
The bench changes the operands immediately after the read edge. A core that samples its inputs late, or that adds them combinationally, would then report a sum built from the changed values.

Sums that wrap past 2^32 are included. A core that keeps a carry, or that drops one operand, would give the wrong result on those cases.

The bench also holds start high through a whole transaction. A core that restarts on a busy-time start, or that passes through idle between back-to-back requests, would show ready too early or raise idle between them.

Finally, the bench asserts reset in the middle of a transaction. The strobes must drop at once, and a later transaction must still produce the correct result.

// File: rtl/hs_add_pkg.sv
package hs_add_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_CALC = 2'd2,
    ST_DONE = 2'd3
  } hs_state_e;

endpackage

// File: rtl/hs_add_rst_sync.sv
module hs_add_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/hs_add_ctrl.sv
module hs_add_ctrl
  import hs_add_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic idle_o,
  output logic ready_o,
  output logic done_o,
  output logic cap_en_o,
  output logic res_en_o
);

  hs_state_e state_q, state_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_READ;
      ST_READ: state_d = ST_CALC;
      ST_CALC: state_d = ST_DONE;
      ST_DONE: state_d = start_i ? ST_READ : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign ready_o  = (state_q == ST_CALC);
  assign done_o   = (state_q == ST_DONE);
  assign cap_en_o = (state_q == ST_READ);
  assign res_en_o = (state_q == ST_CALC);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && start_i) |=> (!idle_o && !ready_o && !done_o));

  // R3
  ready_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en_o |=> (ready_o && !idle_o));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready_o, done_o, idle_o}));

  // R7
  back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> idle_o);

  // R8
  chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> (!idle_o && !ready_o && !done_o));

  // R9
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && !start_i) |=> idle_o);

endmodule

// File: rtl/hs_add_capture.sv
module hs_add_capture #(
  parameter int DATA_W = 32,
  parameter int N_OPS  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en_i,
  input  logic [N_OPS-1:0][DATA_W-1:0]  ops_i,
  output logic [N_OPS-1:0][DATA_W-1:0]  ops_o
);

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    logic [DATA_W-1:0] op_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    op_q <= '0;
      else if (en_i) op_q <= ops_i[g];
    end
    assign ops_o[g] = op_q;
  end

endmodule

// File: rtl/hs_add_sum.sv
module hs_add_sum #(
  parameter int DATA_W = 32,
  parameter int N_OPS  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en_i,
  input  logic [N_OPS-1:0][DATA_W-1:0]  ops_i,
  output logic [DATA_W-1:0]             res_o
);

  logic [DATA_W-1:0] sum_d;
  logic [DATA_W-1:0] res_q;

  always_comb begin
    sum_d = '0;
    for (int i = 0; i < N_OPS; i++) sum_d = sum_d + ops_i[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (en_i) res_q <= sum_d;
  end

  assign res_o = res_q;

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> $stable(res_q));

endmodule

// File: rtl/hs_add_core.sv
module hs_add_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              idle_o,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              acc_vld_o,
  output logic [DATA_W-1:0] ret_o
);

  localparam int N_OPS = 3;

  logic                         rst_sync_n;
  logic                         cap_en;
  logic                         res_en;
  logic [N_OPS-1:0][DATA_W-1:0] ops_in;
  logic [N_OPS-1:0][DATA_W-1:0] ops_cap;
  logic [DATA_W-1:0]            result;

  assign ops_in = {acc_i, op_b_i, op_a_i};

  hs_add_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hs_add_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .idle_o   (idle_o),
    .ready_o  (ready_o),
    .done_o   (done_o),
    .cap_en_o (cap_en),
    .res_en_o (res_en)
  );

  hs_add_capture #(.DATA_W(DATA_W), .N_OPS(N_OPS)) cap_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_i  (cap_en),
    .ops_i (ops_in),
    .ops_o (ops_cap)
  );

  hs_add_sum #(.DATA_W(DATA_W), .N_OPS(N_OPS)) sum_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_i  (res_en),
    .ops_i (ops_cap),
    .res_o (result)
  );

  assign acc_vld_o = done_o;
  assign acc_o     = result;
  assign ret_o     = result;

  // R4
  result_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (ret_o == DATA_W'($past(op_a_i, 2) + $past(op_b_i, 2) + $past(acc_i, 2))));

  // R5
  vld_follows_ready_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready_o |=> (acc_vld_o && done_o && (acc_o == ret_o)));

  // R5
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_vld_o |=> !acc_vld_o);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (idle_o && !ready_o && !done_o && !acc_vld_o));

endmodule

// File: tb/hs_add_core_tb_top.sv
module hs_add_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] op_a_i, op_b_i, acc_i;
  logic        idle_o, ready_o, done_o, acc_vld_o;
  logic [31:0] acc_o, ret_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hs_add_core #(.DATA_W(32)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_a_i    (op_a_i),
    .op_b_i    (op_b_i),
    .acc_i     (acc_i),
    .idle_o    (idle_o),
    .ready_o   (ready_o),
    .done_o    (done_o),
    .acc_o     (acc_o),
    .acc_vld_o (acc_vld_o),
    .ret_o     (ret_o)
  );

  localparam int NVEC = 8;
  // {a, b, acc}
  localparam logic [95:0] VEC [NVEC] = '{
    {32'd0,          32'd0,          32'd0},
    {32'd1,          32'd2,          32'd3},
    {32'hFFFF_FFFF,  32'd1,          32'd0},
    {32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'hFFFF_FFFF},
    {32'h8000_0000,  32'h8000_0000,  32'd7},
    {32'h1234_5678,  32'h0000_0000,  32'h8765_4321},
    {32'd0,          32'd0,          32'hDEAD_BEEF},
    {32'hAAAA_AAAA,  32'h5555_5555,  32'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge with the core idle
  task automatic txn(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    logic [31:0] exp;
    exp = a + b + c;
    op_a_i = a; op_b_i = b; acc_i = c; start_i = 1'b1;
    @(negedge clk); // first busy cycle
    chk(idle_o == 1'b0, "R2 idle low", 32'(idle_o), 32'd0);
    chk(ready_o == 1'b0 && done_o == 1'b0, "R3 no early strobe", 32'({ready_o, done_o}), 32'd0);
    start_i = 1'b0;
    @(negedge clk); // second busy cycle
    chk(ready_o == 1'b1, "R3 ready", 32'(ready_o), 32'd1);
    chk(acc_vld_o == 1'b0, "R5 vld not early", 32'(acc_vld_o), 32'd0);
    op_a_i = ~a; op_b_i = ~b; acc_i = c ^ 32'h5A5A_5A5A;
    @(negedge clk); // done cycle
    chk(done_o == 1'b1 && ready_o == 1'b0, "R6 done", 32'({done_o, ready_o}), 32'b10);
    chk(acc_vld_o == 1'b1, "R5 acc valid", 32'(acc_vld_o), 32'd1);
    chk(ret_o == exp, "R4 ret", ret_o, exp);
    chk(acc_o == exp, "R4 acc_o", acc_o, exp);
    @(negedge clk);
    chk(idle_o == 1'b1 && done_o == 1'b0 && acc_vld_o == 1'b0, "R7 back to idle",
        32'({idle_o, done_o, acc_vld_o}), 32'b100);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold;
    rst_n = 1'b0; start_i = 1'b0;
    op_a_i = '0; op_b_i = '0; acc_i = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(idle_o && !ready_o && !done_o && !acc_vld_o, "R1 in reset",
        32'({idle_o, ready_o, done_o, acc_vld_o}), 32'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(idle_o && !ready_o && !done_o && !acc_vld_o, "R1 after release",
        32'({idle_o, ready_o, done_o, acc_vld_o}), 32'b1000);

    for (int i = 0; i < NVEC; i++) txn(VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);

    // R9: idle with start low holds state and result
    hold = ret_o;
    repeat (5) @(negedge clk);
    chk(idle_o && !ready_o && !done_o && !acc_vld_o, "R9 stays idle",
        32'({idle_o, ready_o, done_o, acc_vld_o}), 32'b1000);
    chk(ret_o == hold, "R9 ret held", ret_o, hold);

    // R8: start held high through a transaction, chain a second one
    op_a_i = 32'd10; op_b_i = 32'd20; acc_i = 32'd30; start_i = 1'b1;
    @(negedge clk); // READ
    @(negedge clk); // CALC, start still high must not restart
    chk(ready_o == 1'b1, "R9 busy start ignored", 32'(ready_o), 32'd1);
    @(negedge clk); // DONE with start high
    chk(done_o && ret_o == 32'd60, "R8 first result", ret_o, 32'd60);
    op_a_i = 32'hFFFF_FFF0; op_b_i = 32'h20; acc_i = 32'h3;
    @(negedge clk); // new READ
    chk(idle_o == 1'b0 && ready_o == 1'b0 && done_o == 1'b0, "R8 no idle gap",
        32'({idle_o, ready_o, done_o}), 32'b000);
    start_i = 1'b0;
    @(negedge clk); // CALC
    chk(ready_o == 1'b1, "R8 chained ready", 32'(ready_o), 32'd1);
    op_a_i = '0; op_b_i = '0; acc_i = '0;
    @(negedge clk); // DONE
    chk(done_o && acc_vld_o && ret_o == 32'h13, "R8 chained result", ret_o, 32'h13);
    @(negedge clk);
    chk(idle_o == 1'b1, "R7 idle after chain", 32'(idle_o), 32'd1);

    // R1: reset in the middle of a transaction
    op_a_i = 32'd5; op_b_i = 32'd6; acc_i = 32'd7; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk); // CALC
    rst_n = 1'b0;
    #1;
    chk(idle_o && !ready_o && !done_o && !acc_vld_o, "R1 mid-run reset",
        32'({idle_o, ready_o, done_o, acc_vld_o}), 32'b1000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    txn(32'd100, 32'd200, 32'd300);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule